// File: doc/BRIEF.md
# Gate-Drive Fault Protection Controller

This block is the digital supervisor placed between a PWM command and the output stage of an isolated power-switch gate driver. It turns the PWM command into a gate-on command and watches a desaturation comparator and two supply-good flags. When the switch desaturates, or either supply domain drops out, it shuts the gate off and raises an active-low fault flag. After a desaturation trip the gate is first ramped down through a soft turn-off window.

Once a fault has been taken, the controller does not recover just because the cause has gone. The gate and the fault flag are held low for a minimum mute interval. After that, only a fresh rising edge of the PWM command releases both together, so a partial pulse can never reach the switch. The same rule applies after reset, and it also applies when the supplies first come up.

All durations are parameters counted in clock cycles. Every input is assumed to be synchronous to `clk`. The parameters must satisfy: every duration at least 1, `MUTE_CYC` greater than both `STO_CYC` and `FLTDLY_CYC`, and `FILT_CYC` at least 1.

Top module: `gate_fault_ctrl`

## Requirements
- R1: After reset, `gate_on` is 0, `soft_off` is 0 and `fault_n` is 1. The gate stays off until the qualified PWM command shows a rising edge. A command that is already high when reset ends does not count as an edge.
- R2: A change on `pwm_in` is accepted only after it has been sampled at `GLITCH_CYC` consecutive clock edges; a shorter pulse is dropped. While running, `gate_on` follows the accepted command one edge later, so the input-to-gate latency is `GLITCH_CYC`+1 edges.
- R3: In each on-period, `desat_in` is ignored at the first `BLANK_CYC` edges after `gate_on` rises.
- R4: After blanking, a trip needs `desat_in` high at `FILT_CYC` consecutive edges while the gate is on. A shorter run clears the count and is dropped.
- R5: At the trip edge, `gate_on` drops to 0 and `soft_off` rises to 1. `soft_off` stays high for exactly `STO_CYC` cycles.
- R6: `fault_n` falls exactly `FLTDLY_CYC` cycles after the desaturation trip edge.
- R7: After any fault, `gate_on` and `fault_n` stay low for `MUTE_CYC` cycles. The count starts at the trip, or at the first edge on which both supplies are good again after an undervoltage fault. PWM edges inside the mute window are ignored.
- R8: After the mute window, the next qualified rising edge of the PWM command raises `gate_on` and `fault_n` in the same cycle. A command that stayed high across the window does not release them.
- R9: While either supply-good flag is 0, `gate_on`, `soft_off` and `fault_n` are all 0 in the same cycle, with no soft turn-off.
- R10: An undervoltage during soft turn-off ends `soft_off` at once and restarts the mute count from supply recovery.
- R11: If the PWM command falls during blanking or filtering, the gate turns off normally. The blanking and filter counts restart on the next on-period, and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM gate command, 1 = switch on |
| desat_in | input | 1 | Desaturation comparator flag, 1 = collector voltage above threshold |
| supply_a_ok | input | 1 | Input-side supply good |
| supply_b_ok | input | 1 | Output-side supply good |
| gate_on | output | 1 | Gate-drive on command |
| soft_off | output | 1 | Selects the slow sink path of the output stage |
| fault_n | output | 1 | Fault flag, 0 = fault |

## Verification
The bench places the edge at which a desaturation run starts or stops exactly one cycle either side of the blanking-plus-filter boundary and of the filter boundary alone. A design with an off-by-one counter would trip on the short run or miss the long one. It raises the PWM command inside the mute window and also holds it high across the end of the window. A design that latched edges, or that took a high level as an edge, would release early. It drops a supply in the middle of soft turn-off and times the release from recovery, which exposes a mute timer that is not restarted. It also drops the command half-way through a run of desaturation samples, which catches a filter count that survives the turn-off.

// File: rtl/gfc_pkg.sv
package gfc_pkg;
  typedef enum logic [1:0] {
    ST_ARM   = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAULT = 2'd2,
    ST_REARM = 2'd3
  } seq_state_e;
endpackage

// File: rtl/gfc_pwm_qualifier.sv
module gfc_pwm_qualifier #(
  parameter int GLITCH_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic qual,
  output logic rise
);
  localparam int CW = $clog2(GLITCH_CYC + 1);

  logic [CW-1:0] agree_cnt;
  logic          q_prev;

  // The qualified level resets high: a command already high at reset is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual      <= 1'b1;
      q_prev    <= 1'b1;
      agree_cnt <= '0;
    end else begin
      q_prev <= qual;
      if (raw != qual) begin
        if (agree_cnt == CW'(GLITCH_CYC - 1)) begin
          qual      <= raw;
          agree_cnt <= '0;
        end else begin
          agree_cnt <= agree_cnt + 1'b1;
        end
      end else begin
        agree_cnt <= '0;
      end
    end
  end

  assign rise = qual & ~q_prev;

  a_r2_change_matches_input: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(qual) |-> (qual == $past(raw)));
endmodule

// File: rtl/gfc_desat_monitor.sv
module gfc_desat_monitor #(
  parameter int BLANK_CYC = 23,
  parameter int FILT_CYC  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drive,
  input  logic desat,
  output logic trip
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int FW = $clog2(FILT_CYC + 1);

  logic [BW-1:0] on_cnt;
  logic [FW-1:0] hit_cnt;
  logic          blank_over;
  logic          hit;

  assign blank_over = (on_cnt == BW'(BLANK_CYC));
  assign hit        = drive & blank_over & desat;
  assign trip       = hit & (hit_cnt == FW'(FILT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_cnt <= '0;
    end else if (!drive) begin
      on_cnt <= '0;
    end else if (!blank_over) begin
      on_cnt <= on_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_cnt <= '0;
    end else if (hit && !trip) begin
      hit_cnt <= hit_cnt + 1'b1;
    end else begin
      hit_cnt <= '0;
    end
  end

  a_r11_counts_clear_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |=> (on_cnt == '0 && hit_cnt == '0));
endmodule

// File: rtl/gfc_fault_sequencer.sv
module gfc_fault_sequencer
  import gfc_pkg::*;
#(
  parameter int STO_CYC    = 90,
  parameter int FLTDLY_CYC = 23,
  parameter int MUTE_CYC   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic qual,
  input  logic rise,
  input  logic trip,
  output logic drive,
  output logic soft_off,
  output logic fault_n
);
  localparam int TW = $clog2(MUTE_CYC + 1);

  seq_state_e    st, st_n;
  logic [TW-1:0] tmr, tmr_n;
  logic          uv, uv_n;

  always_comb begin
    st_n  = st;
    tmr_n = tmr;
    uv_n  = uv;
    if (!supply_ok) begin
      st_n  = ST_FAULT;
      tmr_n = '0;
      uv_n  = 1'b1;
    end else begin
      unique case (st)
        ST_ARM, ST_REARM: if (rise) st_n = ST_RUN;
        ST_RUN: begin
          if (trip) begin
            st_n  = ST_FAULT;
            tmr_n = '0;
            uv_n  = 1'b0;
          end
        end
        ST_FAULT: begin
          if (tmr == TW'(MUTE_CYC - 1)) begin
            st_n  = ST_REARM;
            tmr_n = '0;
          end else begin
            tmr_n = tmr + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_ARM;
      tmr   <= '0;
      uv    <= 1'b0;
      drive <= 1'b0;
    end else begin
      st    <= st_n;
      tmr   <= tmr_n;
      uv    <= uv_n;
      drive <= (st_n == ST_RUN) & qual;
    end
  end

  assign soft_off = supply_ok & (st == ST_FAULT) & ~uv & (tmr < TW'(STO_CYC));
  assign fault_n  = supply_ok & (st != ST_REARM) &
                    ~((st == ST_FAULT) & (uv | (tmr >= TW'(FLTDLY_CYC))));

  a_r9_uv_enters_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (st == ST_FAULT && tmr == '0 && uv));
  a_r7_mute_keeps_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAULT) |-> !drive);
  a_r8_release_with_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> drive);
  a_r5_soft_excludes_gate: assert property (@(posedge clk) disable iff (!rst_n)
    soft_off |-> !drive);
endmodule

// File: rtl/gate_fault_ctrl.sv
module gate_fault_ctrl #(
  parameter int GLITCH_CYC = 2,
  parameter int BLANK_CYC  = 23,
  parameter int FILT_CYC   = 16,
  parameter int STO_CYC    = 90,
  parameter int FLTDLY_CYC = 23,
  parameter int MUTE_CYC   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic desat_in,
  input  logic supply_a_ok,
  input  logic supply_b_ok,
  output logic gate_on,
  output logic soft_off,
  output logic fault_n
);
  logic both_ok;
  logic qual_w, rise_w, trip_w, drive_w;

  assign both_ok = supply_a_ok & supply_b_ok;

  gfc_pwm_qualifier #(.GLITCH_CYC(GLITCH_CYC)) u_qual (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (pwm_in),
    .qual (qual_w),
    .rise (rise_w)
  );

  gfc_desat_monitor #(.BLANK_CYC(BLANK_CYC), .FILT_CYC(FILT_CYC)) u_desat (
    .clk  (clk),
    .rst_n(rst_n),
    .drive(drive_w),
    .desat(desat_in),
    .trip (trip_w)
  );

  gfc_fault_sequencer #(
    .STO_CYC(STO_CYC), .FLTDLY_CYC(FLTDLY_CYC), .MUTE_CYC(MUTE_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(both_ok),
    .qual     (qual_w),
    .rise     (rise_w),
    .trip     (trip_w),
    .drive    (drive_w),
    .soft_off (soft_off),
    .fault_n  (fault_n)
  );

  assign gate_on = drive_w & both_ok;

  a_r5_trip_turns_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    trip_w |=> !gate_on);
endmodule

// File: tb/gate_fault_ctrl_test.sv
`timescale 1ns/1ps
module gate_fault_ctrl_test;
  localparam int G = 2, B = 8, F = 5, S = 12, D = 8, M = 60;

  logic clk = 1'b0;
  logic rst_n, pwm, desat, sa, sb;
  logic gate_on, soft_off, fault_n;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  gate_fault_ctrl #(.GLITCH_CYC(G), .BLANK_CYC(B), .FILT_CYC(F),
                    .STO_CYC(S), .FLTDLY_CYC(D), .MUTE_CYC(M)) uut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm), .desat_in(desat),
    .supply_a_ok(sa), .supply_b_ok(sb),
    .gate_on(gate_on), .soft_off(soft_off), .fault_n(fault_n));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  // Behavioural reference: mode 0 waiting after reset, 1 running, 2 fault, 3 waiting after mute.
  int m_lvl, m_lvl_old, m_agree, m_mode, m_age, m_uv, m_drv, m_ontime, m_hits;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_lvl = 1; m_lvl_old = 1; m_agree = 0; m_mode = 0; m_age = 0;
      m_uv = 0; m_drv = 0; m_ontime = 0; m_hits = 0;
    end else begin
      int ok, counting, fire, edge_seen, nmode, nage, nuv;
      ok = sa && sb;
      counting = m_drv && (m_ontime >= B) && desat;
      fire = counting && (m_hits + 1 == F);
      edge_seen = m_lvl && !m_lvl_old;
      nmode = m_mode; nage = m_age; nuv = m_uv;
      if (!ok) begin nmode = 2; nage = 0; nuv = 1; end
      else if (m_mode == 0 || m_mode == 3) begin if (edge_seen) nmode = 1; end
      else if (m_mode == 1) begin if (fire) begin nmode = 2; nage = 0; nuv = 0; end end
      else if (m_age + 1 >= M) begin nmode = 3; nage = 0; end
      else nage = m_age + 1;
      m_hits = (counting && !fire) ? m_hits + 1 : 0;
      m_ontime = m_drv ? ((m_ontime < B) ? m_ontime + 1 : B) : 0;
      m_drv = (nmode == 1) && m_lvl;
      m_mode = nmode; m_age = nage; m_uv = nuv;
      m_lvl_old = m_lvl;
      if (pwm != m_lvl) begin
        if (m_agree + 1 >= G) begin m_lvl = pwm; m_agree = 0; end
        else m_agree++;
      end else m_agree = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int ok;
      ok = sa && sb;
      check("R1 model gate_on", gate_on, m_drv && ok);
      check("R5 model soft_off", soft_off, ok && m_mode == 2 && !m_uv && m_age < S);
      check("R6 model fault_n", fault_n,
            ok && m_mode != 3 && !(m_mode == 2 && (m_uv || m_age >= D)));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: R1 sequence did not complete, actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seen, sc, fd;
    rst_n = 0; pwm = 1; desat = 0; sa = 1; sb = 1;
    tick(3);
    rst_n = 1;
    check("R1 reset gate_on", gate_on, 0);
    check("R1 reset soft_off", soft_off, 0);
    check("R1 reset fault_n", fault_n, 1);
    tick(10);
    check("R1 level high from reset is no edge", gate_on, 0);
    pwm = 0; tick(4); pwm = 1; tick(2);
    check("R2 gate not yet on at G edges", gate_on, 0);
    tick(1);
    check("R1 gate on after first edge", gate_on, 1);

    // R2 glitch rejection and acceptance
    pwm = 0; tick(4);
    check("R2 gate follows fall", gate_on, 0);
    pwm = 1; tick(G - 1); pwm = 0; seen = 0;
    for (int i = 0; i < 6; i++) begin tick(1); if (gate_on) seen = 1; end
    check("R2 short pulse dropped", seen, 0);
    pwm = 1; tick(G); pwm = 0; seen = 0;
    for (int i = 0; i < 6; i++) begin tick(1); if (gate_on) seen = 1; end
    check("R2 full-width pulse passed", seen, 1);
    tick(4);

    // R3 blanking plus filter, one short
    pwm = 1; tick(3);
    check("R3 gate on before desat", gate_on, 1);
    desat = 1; tick(B + F - 1); desat = 0; tick(3);
    check("R3 one-short run no soft_off", soft_off, 0);
    check("R3 one-short run no fault", fault_n, 1);
    check("R3 one-short run gate stays", gate_on, 1);

    // R4 filter alone, one short then exact
    desat = 1; tick(F - 1); desat = 0; tick(2);
    check("R4 short filter run dropped", fault_n, 1);
    check("R4 short filter run no soft_off", soft_off, 0);

    // R3/R4/R5/R6 exact trip
    pwm = 0; tick(4); pwm = 1; tick(3);
    desat = 1; tick(B + F - 1);
    check("R3 no trip one edge early", soft_off, 0);
    tick(1);
    check("R4 trip at boundary", soft_off, 1);
    check("R5 gate off at trip", gate_on, 0);
    desat = 0; sc = 0; fd = -1;
    for (int i = 0; i < S + 6; i++) begin
      if (soft_off) sc++;
      if (!fault_n && fd < 0) fd = i;
      tick(1);
    end
    check("R5 soft_off length", sc, S);
    check("R6 fault flag delay", fd, D);
    // now trip + S + 6; mute ends at trip + M
    pwm = 0; tick(4); pwm = 1; tick(10);
    check("R7 edge in mute ignored gate", gate_on, 0);
    check("R7 edge in mute ignored fault", fault_n, 0);
    tick(M + 5 - (S + 6 + 14));
    check("R8 held level after mute no release", gate_on, 0);
    check("R8 held level keeps fault", fault_n, 0);
    pwm = 0; tick(4); pwm = 1; tick(G);
    check("R8 not yet released", fault_n, 0);
    tick(1);
    check("R8 release gate", gate_on, 1);
    check("R8 release fault", fault_n, 1);

    // R9 undervoltage while running
    sb = 0; #1;
    check("R9 uv gate off", gate_on, 0);
    check("R9 uv fault", fault_n, 0);
    check("R9 uv no soft", soft_off, 0);
    tick(5); sb = 1;
    tick(M - 1);
    check("R7 mute from recovery", fault_n, 0);
    tick(5);
    check("R8 no edge no release after uv", gate_on, 0);
    pwm = 0; tick(4); pwm = 1; tick(3);
    check("R8 uv release gate", gate_on, 1);
    check("R8 uv release fault", fault_n, 1);

    // R10 undervoltage during soft turn-off
    pwm = 0; tick(4); pwm = 1; tick(3);
    desat = 1; tick(B + F);
    check("R10 soft_off entered", soft_off, 1);
    desat = 0; tick(3);
    sa = 0; #1;
    check("R10 soft cut by uv", soft_off, 0);
    check("R10 gate off", gate_on, 0);
    check("R10 fault low", fault_n, 0);
    tick(2); sa = 1;
    tick(M - 10); pwm = 0; tick(3); pwm = 1; tick(8);
    check("R10 mute restarted gate", gate_on, 0);
    check("R10 mute restarted fault", fault_n, 0);
    pwm = 0; tick(4); pwm = 1; tick(3);
    check("R10 released later", fault_n, 1);

    // R11 command falls during filtering
    pwm = 0; tick(4); pwm = 1; tick(3);
    desat = 1; tick(B); pwm = 0; tick(B + F + 5);
    check("R11 no fault after fall", fault_n, 1);
    check("R11 gate off normally", gate_on, 0);
    check("R11 no soft", soft_off, 0);
    desat = 0; pwm = 1; tick(3);
    check("R11 turns on again", gate_on, 1);
    desat = 1; tick(B + F - 1); desat = 0; tick(2);
    check("R11 counts restarted", fault_n, 1);
    check("R11 gate stays on", gate_on, 1);
    tick(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule